// File: doc/BRIEF.md
# Manual-Mode SPI Register Front End

This block sits between a register bus and the serial engine of a flash SPI controller. Normally the controller serves memory-mapped reads on its own. When software wants to issue arbitrary flash commands, it parks the automatic read path, switches the controller into manual mode, and then feeds the serial engine by hand. It does this through an opcode queue, a transmit byte queue and a receive byte queue. Every queue is reached through plain register writes and reads. Each register offset is a 32-bit word.

An opcode word carries a 5-bit command in bits 13:9 and a 9-bit length in bits 8:0. Software first writes the word into a staging register, then fires a push strobe. The serial engine takes opcodes and transmit bytes through valid/ready ports and returns received bytes through a valid/ready producer port. It pulses a completion input when it has fully executed an opcode. A busy input from the automatic read path feeds a status register and a clash interrupt.

Top module: `spi_manual_frontend`

## Requirements
- R1: After reset the mode toggle (0x14) and manual enable (0x20) read 0, read-idle enable (0x04) reads 1, interrupt enable (0x90) reads 1, DMA-bridge enable (0x130) reads 0, opcode status (0x24) and data status (0x3C) read 1, and any offset outside the map reads 0.
- R2: A write to 0x28 only stages the full 32-bit word, which reads back at 0x28. A write of 1 to 0x30 pushes bits 13:9 (command) and 8:0 (length) of the staged word into the opcode queue, which then presents that word on opData.
- R3: Manual mode is in force only while 0x14 holds 9 and bit 0 of 0x20 holds 1. Outside it, opcode pushes, transmit writes and receive pops are ignored, and opValid and txValid stay low.
- R4: Bit 0 of 0x24 (opcode empty) stays 0 after the engine takes the last queued opcode, and rises only after an opDone pulse.
- R5: Each write to 0x38 in manual mode queues bits 7:0 as one transmit byte with no strobe. Bytes leave on txData in write order. Bit 0 of 0x34 reads 1 when the transmit queue holds its full depth.
- R6: 0x44 shows the oldest received byte in bits 7:0, or 0 when the receive queue is empty. Writing 1 to 0x40 discards that byte. Bit 0 of 0x3C reads 1 while the receive queue is empty.
- R7: A push into a full queue or a pop of an empty queue leaves the queue unchanged. It sets a sticky bit 1 at 0x24 (opcode queue) or at 0x3C (transmit or receive queue). Writing a word with bit 1 set to that offset clears the sticky bit.
- R8: 0x18 reads nonzero while read-idle enable is 1 or autoBusy is high, and reads 0 once read-idle enable is cleared and autoBusy is low. The readIdleEn output follows bit 0 of 0x04.
- R9: irq goes high one cycle after manual mode and autoBusy are both true while bit 0 of 0x90 is 1. It stays low while that bit is 0.
- R10: Bit 0 of 0x130 drives dmaBridgeEn.
- R11: When the engine delivers a received byte in the same cycle as a software pop, the pop removes the old head and the new byte is kept. The queue then shows the new byte and is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 9 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| autoBusy | input | 1 | Automatic read path is busy |
| readIdleEn | output | 1 | Read-idle enable to the automatic path |
| manualMode | output | 1 | Manual mode in force |
| irq | output | 1 | Mode clash interrupt |
| dmaBridgeEn | output | 1 | DMA-bridge enable |
| opValid | output | 1 | Opcode available to the engine |
| opData | output | 14 | Opcode word: command 13:9, length 8:0 |
| opReady | input | 1 | Engine takes the opcode |
| opDone | input | 1 | Engine finished the last taken opcode |
| txValid | output | 1 | Transmit byte available |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Engine takes the transmit byte |
| rxValid | input | 1 | Engine delivers a received byte |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Receive queue has room |

## Verification
The receive queue can be written by the engine and popped by software in the same clock cycle. The bench provokes this by holding one byte in the queue and then raising rxValid in the very cycle that carries the pop write to 0x40. It judges the result at the register port: 0x44 must show the newly delivered byte and bit 0 of 0x3C must stay 0. Draining once more must then empty the queue.

// File: rtl/spi_mfe_pkg.sv
package spi_mfe_pkg;
  localparam int MFE_ADDR_W = 9;

  localparam logic [MFE_ADDR_W-1:0] OFS_IDLE   = 9'h004;
  localparam logic [MFE_ADDR_W-1:0] OFS_MODE   = 9'h014;
  localparam logic [MFE_ADDR_W-1:0] OFS_FSM    = 9'h018;
  localparam logic [MFE_ADDR_W-1:0] OFS_MANEN  = 9'h020;
  localparam logic [MFE_ADDR_W-1:0] OFS_OPSTAT = 9'h024;
  localparam logic [MFE_ADDR_W-1:0] OFS_OPSTG  = 9'h028;
  localparam logic [MFE_ADDR_W-1:0] OFS_OPFULL = 9'h02C;
  localparam logic [MFE_ADDR_W-1:0] OFS_OPPUSH = 9'h030;
  localparam logic [MFE_ADDR_W-1:0] OFS_TXFULL = 9'h034;
  localparam logic [MFE_ADDR_W-1:0] OFS_TXWR   = 9'h038;
  localparam logic [MFE_ADDR_W-1:0] OFS_RXSTAT = 9'h03C;
  localparam logic [MFE_ADDR_W-1:0] OFS_RXPOP  = 9'h040;
  localparam logic [MFE_ADDR_W-1:0] OFS_RXHEAD = 9'h044;
  localparam logic [MFE_ADDR_W-1:0] OFS_IER    = 9'h090;
  localparam logic [MFE_ADDR_W-1:0] OFS_DMA    = 9'h130;

  localparam logic [3:0] MODE_MANUAL_CODE = 4'd9;

  typedef struct packed {
    logic stageLd;
    logic opPush;
    logic txPush;
    logic rxPop;
  } mfe_strobe_t;

  typedef struct packed {
    logic opFull;
    logic opEmptyRep;
    logic txFull;
    logic rxEmpty;
  } mfe_status_t;
endpackage

// File: rtl/mfe_fifo.sv
module mfe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R7: a push into a full queue leaves the occupancy alone
  a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));

  // R6: a lone pop of a non-empty queue removes exactly one entry
  a_r6_pop_removes_one: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !empty && !push) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/mfe_datapath.sv
module mfe_datapath
  import spi_mfe_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int OP_W     = 14,
  parameter int BYTE_W   = 8,
  parameter int OP_DEPTH = 4,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mfe_strobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              manualMode,
  output mfe_status_t       status,
  output logic [DATA_W-1:0] stagedWord,
  output logic [BYTE_W-1:0] rxHead,
  output logic              opValid,
  output logic [OP_W-1:0]   opData,
  input  logic              opReady,
  input  logic              opDone,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady
);
  logic              opFull, opEmpty, txFull, txEmpty, rxFull, rxEmpty;
  logic              opPop, txPop, opPending;
  logic [BYTE_W-1:0] rxRaw;

  always_ff @(posedge clk) begin
    if (!rstN)               stagedWord <= '0;
    else if (strobe.stageLd) stagedWord <= wdata;
  end

  assign opValid = !opEmpty && manualMode;
  assign opPop   = opValid && opReady;
  assign txValid = !txEmpty && manualMode;
  assign txPop   = txValid && txReady;
  assign rxReady = !rxFull;

  // completion tracking: taking an opcode wins over a same-cycle opDone
  always_ff @(posedge clk) begin
    if (!rstN)       opPending <= 1'b0;
    else if (opPop)  opPending <= 1'b1;
    else if (opDone) opPending <= 1'b0;
  end

  mfe_fifo #(.W(OP_W), .DEPTH(OP_DEPTH)) u_opq (
    .clk(clk), .rstN(rstN), .push(strobe.opPush), .pushData(stagedWord[OP_W-1:0]),
    .pop(opPop), .head(opData), .full(opFull), .empty(opEmpty));

  mfe_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(strobe.txPush), .pushData(wdata[BYTE_W-1:0]),
    .pop(txPop), .head(txData), .full(txFull), .empty(txEmpty));

  mfe_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(rxValid), .pushData(rxData),
    .pop(strobe.rxPop), .head(rxRaw), .full(rxFull), .empty(rxEmpty));

  assign rxHead = rxEmpty ? '0 : rxRaw;

  always_comb begin
    status.opFull     = opFull;
    status.opEmptyRep = opEmpty && !opPending;
    status.txFull     = txFull;
    status.rxEmpty    = rxEmpty;
  end

  // R4: after the engine takes an opcode, empty is not reported next cycle
  a_r4_empty_waits_done: assert property (@(posedge clk) disable iff (!rstN)
    opPop |=> !status.opEmptyRep);

  // R3: nothing is offered to the engine outside manual mode
  a_r3_offer_only_manual: assert property (@(posedge clk) disable iff (!rstN)
    (opValid || txValid) |-> manualMode);
endmodule

// File: rtl/mfe_ctrl.sv
module mfe_ctrl
  import spi_mfe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [MFE_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [3:0]            cfgBits,
  input  mfe_status_t           status,
  input  logic [DATA_W-1:0]     stagedWord,
  input  logic [BYTE_W-1:0]     rxHead,
  input  logic                  autoBusy,
  output mfe_strobe_t           strobe,
  output logic                  manualMode,
  output logic                  readIdleEn,
  output logic                  irq,
  output logic                  dmaBridgeEn,
  output logic [DATA_W-1:0]     regRdata
);
  logic [3:0] modeTog;
  logic       manualEn, ierBit, opErr, dataErr;
  logic       opErrSet, dataErrSet, opErrClr, dataErrClr;

  function automatic logic hit(input logic [MFE_ADDR_W-1:0] ofs);
    return regWrEn && (regAddr == ofs);
  endfunction

  assign manualMode = (modeTog == MODE_MANUAL_CODE) && manualEn;

  always_comb begin
    strobe.stageLd = hit(OFS_OPSTG);
    strobe.opPush  = hit(OFS_OPPUSH) && cfgBits[0] && manualMode;
    strobe.txPush  = hit(OFS_TXWR) && manualMode;
    strobe.rxPop   = hit(OFS_RXPOP) && cfgBits[0] && manualMode;
  end

  assign opErrSet   = strobe.opPush && status.opFull;
  assign dataErrSet = (strobe.txPush && status.txFull) || (strobe.rxPop && status.rxEmpty);
  assign opErrClr   = hit(OFS_OPSTAT) && cfgBits[1];
  assign dataErrClr = hit(OFS_RXSTAT) && cfgBits[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readIdleEn  <= 1'b1;
      modeTog     <= '0;
      manualEn    <= 1'b0;
      ierBit      <= 1'b1;
      dmaBridgeEn <= 1'b0;
      opErr       <= 1'b0;
      dataErr     <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (hit(OFS_IDLE))  readIdleEn  <= cfgBits[0];
      if (hit(OFS_MODE))  modeTog     <= cfgBits;
      if (hit(OFS_MANEN)) manualEn    <= cfgBits[0];
      if (hit(OFS_IER))   ierBit      <= cfgBits[0];
      if (hit(OFS_DMA))   dmaBridgeEn <= cfgBits[0];
      if (opErrSet)        opErr <= 1'b1;
      else if (opErrClr)   opErr <= 1'b0;
      if (dataErrSet)      dataErr <= 1'b1;
      else if (dataErrClr) dataErr <= 1'b0;
      irq <= manualMode && autoBusy && ierBit;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_IDLE:   regRdata[0]   = readIdleEn;
      OFS_MODE:   regRdata[3:0] = modeTog;
      OFS_FSM:    regRdata[0]   = readIdleEn || autoBusy;
      OFS_MANEN:  regRdata[0]   = manualEn;
      OFS_OPSTAT: regRdata[1:0] = {opErr, status.opEmptyRep};
      OFS_OPSTG:  regRdata      = stagedWord;
      OFS_OPFULL: regRdata[0]   = status.opFull;
      OFS_TXFULL: regRdata[0]   = status.txFull;
      OFS_RXSTAT: regRdata[1:0] = {dataErr, status.rxEmpty};
      OFS_RXHEAD: regRdata[BYTE_W-1:0] = rxHead;
      OFS_IER:    regRdata[0]   = ierBit;
      OFS_DMA:    regRdata[0]   = dmaBridgeEn;
      default:    regRdata      = '0;
    endcase
  end

  // R9: a masked clash never raises the interrupt
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    !ierBit |=> !irq);

  // R7: an overflowing opcode push leaves the sticky bit set
  a_r7_op_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (opErr && !opErrClr) |=> opErr);
endmodule

// File: rtl/spi_manual_frontend.sv
module spi_manual_frontend
  import spi_mfe_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CMD_W    = 5,
  parameter int LEN_W    = 9,
  parameter int BYTE_W   = 8,
  parameter int OP_DEPTH = 4,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [MFE_ADDR_W-1:0]    regAddr,
  input  logic                     regWrEn,
  input  logic [DATA_W-1:0]        regWdata,
  output logic [DATA_W-1:0]        regRdata,
  input  logic                     autoBusy,
  output logic                     readIdleEn,
  output logic                     manualMode,
  output logic                     irq,
  output logic                     dmaBridgeEn,
  output logic                     opValid,
  output logic [CMD_W+LEN_W-1:0]   opData,
  input  logic                     opReady,
  input  logic                     opDone,
  output logic                     txValid,
  output logic [BYTE_W-1:0]        txData,
  input  logic                     txReady,
  input  logic                     rxValid,
  input  logic [BYTE_W-1:0]        rxData,
  output logic                     rxReady
);
  localparam int OP_W = CMD_W + LEN_W;

  mfe_strobe_t       strobe;
  mfe_status_t       status;
  logic [DATA_W-1:0] stagedWord;
  logic [BYTE_W-1:0] rxHead;

  mfe_ctrl #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .cfgBits(regWdata[3:0]), .status(status), .stagedWord(stagedWord),
    .rxHead(rxHead), .autoBusy(autoBusy), .strobe(strobe),
    .manualMode(manualMode), .readIdleEn(readIdleEn), .irq(irq),
    .dmaBridgeEn(dmaBridgeEn), .regRdata(regRdata));

  mfe_datapath #(.DATA_W(DATA_W), .OP_W(OP_W), .BYTE_W(BYTE_W),
                 .OP_DEPTH(OP_DEPTH), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata),
    .manualMode(manualMode), .status(status), .stagedWord(stagedWord),
    .rxHead(rxHead), .opValid(opValid), .opData(opData), .opReady(opReady),
    .opDone(opDone), .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady));
endmodule

// File: tb/spi_manual_frontend_tb.sv
module spi_manual_frontend_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        autoBusy = 1'b0;
  logic        readIdleEn, manualMode, irq, dmaBridgeEn;
  logic        opValid;
  logic [13:0] opData;
  logic        opReady = 1'b0, opDone = 1'b0;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxReady;

  int total = 0;
  int bad = 0;

  spi_manual_frontend u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .autoBusy(autoBusy),
    .readIdleEn(readIdleEn), .manualMode(manualMode), .irq(irq),
    .dmaBridgeEn(dmaBridgeEn), .opValid(opValid), .opData(opData),
    .opReady(opReady), .opDone(opDone), .txValid(txValid), .txData(txData),
    .txReady(txReady), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [8:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(req, regRdata, exp);
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic t_reset;
    rdChk("R1 mode", 9'h014, 0);
    rdChk("R1 manen", 9'h020, 0);
    rdChk("R1 idle", 9'h004, 1);
    rdChk("R1 ier", 9'h090, 1);
    rdChk("R1 dma", 9'h130, 0);
    rdChk("R1 opstat", 9'h024, 1);
    rdChk("R1 rxstat", 9'h03C, 1);
    rdChk("R1 undefined", 9'h100, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_auto_gating;
    rxPush(8'h5A);
    wr(9'h038, 32'h77);
    wr(9'h028, 32'h123);
    wr(9'h030, 32'h1);
    wr(9'h040, 32'h1);
    chk("R3 txValid auto", {31'b0, txValid}, 0);
    chk("R3 opValid auto", {31'b0, opValid}, 0);
    rdChk("R3 op push ignored", 9'h024, 1);
    rdChk("R3 pop ignored", 9'h044, 32'h5A);
    rdChk("R3 no data err", 9'h03C, 0);
  endtask

  task automatic t_fsm_enter;
    rdChk("R8 fsm idle-on", 9'h018, 1);
    wr(9'h004, 0);
    chk("R8 readIdleEn out", {31'b0, readIdleEn}, 0);
    rdChk("R8 fsm idle", 9'h018, 0);
    autoBusy = 1'b1;
    rdChk("R8 fsm busy", 9'h018, 1);
    autoBusy = 1'b0;
    wr(9'h014, 9);
    wr(9'h020, 1);
    chk("R3 manual on", {31'b0, manualMode}, 1);
  endtask

  task automatic t_irq;
    @(negedge clk); autoBusy = 1'b1;
    @(negedge clk);
    chk("R9 irq clash", {31'b0, irq}, 1);
    wr(9'h090, 0);
    @(negedge clk);
    chk("R9 irq masked", {31'b0, irq}, 0);
    autoBusy = 1'b0;
    wr(9'h090, 1);
    @(negedge clk);
    chk("R9 irq idle", {31'b0, irq}, 0);
  endtask

  task automatic t_opcode;
    wr(9'h028, 32'hABCD_1805);
    chk("R2 staged not queued", {31'b0, opValid}, 0);
    rdChk("R2 staged readback", 9'h028, 32'hABCD_1805);
    rdChk("R2 still empty", 9'h024, 1);
    wr(9'h030, 1);
    chk("R2 opValid", {31'b0, opValid}, 1);
    chk("R2 opData", {18'b0, opData}, 32'h1805);
    rdChk("R4 not empty", 9'h024, 0);
    opReady = 1'b1;
    @(negedge clk); opReady = 1'b0;
    chk("R4 taken", {31'b0, opValid}, 0);
    rdChk("R4 wait done", 9'h024, 0);
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
    rdChk("R4 after done", 9'h024, 1);
  endtask

  task automatic t_op_full;
    for (int k = 0; k < 4; k++) begin
      wr(9'h028, 32'h0200 + k);
      wr(9'h030, 1);
    end
    rdChk("R7 op full", 9'h02C, 1);
    wr(9'h028, 32'h3FFF);
    wr(9'h030, 1);
    rdChk("R7 op err", 9'h024, 2);
    for (int k = 0; k < 4; k++) begin
      chk("R7 op order", {18'b0, opData}, 32'h0200 + k);
      opReady = 1'b1;
      @(negedge clk); opReady = 1'b0;
    end
    chk("R7 op drained", {31'b0, opValid}, 0);
    opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
    rdChk("R7 err sticky", 9'h024, 3);
    wr(9'h024, 2);
    rdChk("R7 err cleared", 9'h024, 1);
  endtask

  task automatic t_tx;
    logic [7:0] exp [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    for (int k = 0; k < 4; k++) wr(9'h038, {24'hFFFFFF, exp[k]});
    rdChk("R5 tx full", 9'h034, 1);
    wr(9'h038, 32'hEE);
    rdChk("R7 tx overflow err", 9'h03C, 2);
    for (int k = 0; k < 4; k++) begin
      chk("R5 tx order", {24'b0, txData}, {24'b0, exp[k]});
      txReady = 1'b1;
      @(negedge clk); txReady = 1'b0;
    end
    chk("R5 tx drained", {31'b0, txValid}, 0);
    rdChk("R5 tx not full", 9'h034, 0);
    wr(9'h03C, 2);
    rdChk("R7 data err cleared", 9'h03C, 0);
  endtask

  task automatic t_rx;
    rxPush(8'h11);
    rxPush(8'h22);
    rdChk("R6 head oldest", 9'h044, 32'h5A);
    wr(9'h040, 1);
    rdChk("R6 head next", 9'h044, 32'h11);
    wr(9'h040, 1);
    rdChk("R6 head last", 9'h044, 32'h22);
    wr(9'h040, 1);
    rdChk("R6 empty", 9'h03C, 1);
    rdChk("R6 empty head", 9'h044, 0);
    wr(9'h040, 1);
    rdChk("R7 underflow err", 9'h03C, 3);
    wr(9'h03C, 2);
    rdChk("R7 underflow cleared", 9'h03C, 1);
  endtask

  task automatic t_same_cycle;
    rxPush(8'h33);
    @(negedge clk);
    regAddr = 9'h040; regWdata = 1; regWrEn = 1'b1;
    rxValid = 1'b1; rxData = 8'h44;
    @(negedge clk);
    regWrEn = 1'b0; rxValid = 1'b0;
    rdChk("R11 new head", 9'h044, 32'h44);
    rdChk("R11 not empty", 9'h03C, 0);
    wr(9'h040, 1);
    rdChk("R11 drained", 9'h03C, 1);
  endtask

  task automatic t_dma;
    wr(9'h130, 1);
    chk("R10 dma on", {31'b0, dmaBridgeEn}, 1);
    wr(9'h130, 0);
    chk("R10 dma off", {31'b0, dmaBridgeEn}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_auto_gating();
    t_fsm_enter();
    t_irq();
    t_opcode();
    t_op_full();
    t_tx();
    t_rx();
    t_same_cycle();
    t_dma();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule